// File: doc/BRIEF.md
# Run-Time Operator Configuration Sequencer

This block sits beside a single processing operator whose function can be changed while the chip runs. The change happens in one of two ways. In the first, a select value picks one of several parameter sets already held inside the operator. In the second, a separate loader rewrites the operator's logic. The sequencer follows a schedule of operation codes that is fixed when the block is built. The schedule index wraps around at its end. An entry can be marked conditional, in which case one condition input chooses between two candidate codes.

As soon as the operator reports that its current operation is finished, the sequencer works out the next code. It asks for that configuration straight away, so the reload can overlap other work, and it does not wait until the operation is actually due. If the next code equals the one already loaded, no request is made. For a conditional entry, the request goes out in the cycle after the selecting value becomes valid. The sequencer gates the operator's enable so that the operator never runs before its configuration is in place. A start request that arrives early is held until the configuration is in place.

Top module: `cfgmgr_top`

## Requirements
- R1: While reset is high and in the first sampled cycle of reset, `mgr_state` reads 0 (idle), `op_enable`, `ld_req` and `configured` are 0, and `sched_idx` is 0. The state encoding is 0 idle, 1 configuring, 2 ready, 3 busy.
- R2: In loader mode, one cycle after reset is released the block raises `ld_req` with `ld_code` equal to schedule entry 0, and enters state 1. Only one request is outstanding at a time: `ld_req` and `ld_code` hold steady until `ld_ack`.
- R3: `op_enable` is high only in state 3. It is never high while `ld_req` is high or while `configured` is low.
- R4: A `start_req` in state 2 gives state 3 with `op_enable` high one cycle later. A `start_req` in state 0 or 1 is held, and the block goes straight to state 3 when the configuration lands. A `start_req` in state 3 is discarded.
- R5: `op_done` in state 3 gives state 0 one cycle later, with `sched_idx` advanced by one. After entry N_ENTRIES-1 the index wraps to 0.
- R6: When the next code equals the loaded code, no request is made. The block moves from state 0 to state 2 one cycle later.
- R7: A conditional entry keeps the block in state 0, with no request, until its `cond_valid` bit is high. The chosen code is the second candidate when the matching `cond_val` bit is 1 and the first candidate when it is 0. The request appears one cycle later. In the default schedule, entry 2 is conditional on condition 0 with candidates 2 and 5. Entries 0, 1 and 3 hold codes 1, 1 and 3.
- R8: `ld_ack` in state 1 makes `cfg_code` equal to `ld_code`, raises `configured` and drops `ld_req` one cycle later.
- R9: `ld_ack` outside state 1 has no effect on the state or on `cfg_code`.
- R10: In parameter-select mode, `ld_req` is never raised. A differing code appears on `cfg_code` one cycle after the block enters state 0 with the target resolved, together with state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to run the current operation |
| op_done | input | 1 | Operator finished the current operation |
| cond_valid | input | N_COND | Condition value is known, one bit per condition |
| cond_val | input | N_COND | Condition values |
| ld_ack | input | 1 | Loader finished the requested load |
| op_enable | output | 1 | Operator enable |
| configured | output | 1 | Operator holds a valid configuration |
| mgr_state | output | 2 | Sequencer state |
| sched_idx | output | IDX_W | Current schedule entry |
| cfg_code | output | CODE_W | Loaded configuration code; parameter select in parameter-select mode |
| ld_req | output | 1 | Load request to the loader |
| ld_code | output | CODE_W | Code requested from the loader |

## Verification
Every result depends on one register stage. A start, a done, an acknowledge or a valid condition changes the outputs at the next rising edge. The resolution in state 0 adds one more edge. So a code change or a skipped request shows one edge after the idle state is seen. The bench drives inputs on falling edges and reads outputs on the next falling edge. It reads exactly one edge after a single-cycle stimulus, and two edges after a done whose next entry needs resolving. Loader latency is random, so ready and busy are awaited by polling on falling edges with a bound. Request counts and enable violations are gathered just after each rising edge.

// File: rtl/cfgmgr_pkg.sv
package cfgmgr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONFIG = 2'd1,
        ST_READY  = 2'd2,
        ST_BUSY   = 2'd3
    } mgr_state_e;

    function automatic int unsigned bits_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cfgmgr_sched.sv
module cfgmgr_sched #(
    parameter int unsigned N_ENTRIES = 4,
    parameter int unsigned CODE_W    = 3,
    parameter int unsigned N_COND    = 2,
    parameter int unsigned CSEL_W    = 1,
    parameter int unsigned IDX_W     = 2,
    parameter logic [N_ENTRIES*CODE_W-1:0] SCHED_A       = '0,
    parameter logic [N_ENTRIES*CODE_W-1:0] SCHED_B       = '0,
    parameter logic [N_ENTRIES-1:0]        SCHED_IS_COND = '0,
    parameter logic [N_ENTRIES*CSEL_W-1:0] SCHED_CSEL    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [N_COND-1:0] cond_valid,
    input  logic [N_COND-1:0] cond_val,
    output logic [IDX_W-1:0]  idx,
    output logic              tgt_valid,
    output logic [CODE_W-1:0] tgt_code
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    logic [CODE_W-1:0] code_a [N_ENTRIES];
    logic [CODE_W-1:0] code_b [N_ENTRIES];
    logic [CSEL_W-1:0] csel   [N_ENTRIES];

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        assign code_a[e] = SCHED_A[e*CODE_W +: CODE_W];
        assign code_b[e] = SCHED_B[e*CODE_W +: CODE_W];
        assign csel[e]   = SCHED_CSEL[e*CSEL_W +: CSEL_W];
    end

    logic [CSEL_W-1:0] sel;
    logic              sel_ok;

    always_comb begin
        sel       = csel[idx];
        sel_ok    = (int'(sel) < N_COND);
        tgt_code  = code_a[idx];
        tgt_valid = 1'b1;
        if (SCHED_IS_COND[idx]) begin
            tgt_valid = sel_ok && cond_valid[sel];
            if (sel_ok && cond_val[sel]) begin
                tgt_code = code_b[idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/cfgmgr_hold.sv
module cfgmgr_hold #(
    parameter bit          PARAM_MODE = 1'b0,
    parameter int unsigned CODE_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              ack_ok,
    input  logic [CODE_W-1:0] tgt_code,
    output logic [CODE_W-1:0] cur_code,
    output logic              cur_valid,
    output logic [CODE_W-1:0] ld_code,
    output logic              cfg_land
);
    if (PARAM_MODE) begin : g_param
        // The select takes effect at once: landing coincides with the issue.
        assign cfg_land = issue;
        assign ld_code  = '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                cur_code  <= '0;
                cur_valid <= 1'b0;
            end else if (issue) begin
                cur_code  <= tgt_code;
                cur_valid <= 1'b1;
            end
        end
    end else begin : g_swap
        logic [CODE_W-1:0] req_code;
        assign cfg_land = ack_ok;
        assign ld_code  = req_code;
        always_ff @(posedge clk) begin
            if (rst) begin
                req_code  <= '0;
                cur_code  <= '0;
                cur_valid <= 1'b0;
            end else begin
                if (issue) begin
                    req_code <= tgt_code;
                end
                if (ack_ok) begin
                    cur_code  <= req_code;
                    cur_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfgmgr_fsm.sv
module cfgmgr_fsm #(
    parameter int unsigned CODE_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tgt_valid,
    input  logic [CODE_W-1:0]      tgt_code,
    input  logic                   cur_valid,
    input  logic [CODE_W-1:0]      cur_code,
    input  logic                   cfg_land,
    input  logic                   start_req,
    input  logic                   op_done,
    input  logic                   ld_ack,
    output cfgmgr_pkg::mgr_state_e state,
    output logic                   issue,
    output logic                   ack_ok,
    output logic                   advance
);
    import cfgmgr_pkg::*;

    mgr_state_e nxt;
    logic       pend, pend_nxt, match, go_run;

    always_comb begin
        match   = cur_valid && (tgt_code == cur_code);
        issue   = (state == ST_IDLE) && tgt_valid && !match;
        ack_ok  = (state == ST_CONFIG) && ld_ack;
        advance = (state == ST_BUSY) && op_done;
        go_run  = pend || start_req;

        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (tgt_valid) begin
                    if (match || cfg_land) begin
                        nxt = go_run ? ST_BUSY : ST_READY;
                    end else begin
                        nxt = ST_CONFIG;
                    end
                end
            end
            ST_CONFIG: begin
                if (cfg_land) begin
                    nxt = go_run ? ST_BUSY : ST_READY;
                end
            end
            ST_READY: begin
                if (start_req) begin
                    nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (op_done) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase

        if ((state == ST_IDLE || state == ST_CONFIG) && nxt != ST_BUSY) begin
            pend_nxt = go_run;
        end else begin
            pend_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
        end else begin
            state <= nxt;
            pend  <= pend_nxt;
        end
    end

endmodule

// File: rtl/cfgmgr_top.sv
module cfgmgr_top #(
    parameter int unsigned N_ENTRIES  = 4,
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned N_COND     = 2,
    parameter bit          PARAM_MODE = 1'b0,
    parameter int unsigned CSEL_W     = cfgmgr_pkg::bits_for(N_COND),
    parameter logic [N_ENTRIES*CODE_W-1:0] SCHED_A       = {3'd3, 3'd2, 3'd1, 3'd1},
    parameter logic [N_ENTRIES*CODE_W-1:0] SCHED_B       = {3'd3, 3'd5, 3'd1, 3'd1},
    parameter logic [N_ENTRIES-1:0]        SCHED_IS_COND = 4'b0100,
    parameter logic [N_ENTRIES*CSEL_W-1:0] SCHED_CSEL    = '0,
    parameter int unsigned IDX_W = cfgmgr_pkg::bits_for(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              op_done,
    input  logic [N_COND-1:0] cond_valid,
    input  logic [N_COND-1:0] cond_val,
    input  logic              ld_ack,
    output logic              op_enable,
    output logic              configured,
    output logic [1:0]        mgr_state,
    output logic [IDX_W-1:0]  sched_idx,
    output logic [CODE_W-1:0] cfg_code,
    output logic              ld_req,
    output logic [CODE_W-1:0] ld_code
);
    import cfgmgr_pkg::*;

    mgr_state_e        state;
    logic              tgt_valid, issue, ack_ok, advance, cur_valid, cfg_land;
    logic [CODE_W-1:0] tgt_code, cur_code;

    cfgmgr_sched #(
        .N_ENTRIES(N_ENTRIES), .CODE_W(CODE_W), .N_COND(N_COND),
        .CSEL_W(CSEL_W), .IDX_W(IDX_W),
        .SCHED_A(SCHED_A), .SCHED_B(SCHED_B),
        .SCHED_IS_COND(SCHED_IS_COND), .SCHED_CSEL(SCHED_CSEL)
    ) u_sched (
        .clk(clk), .rst(rst), .advance(advance),
        .cond_valid(cond_valid), .cond_val(cond_val),
        .idx(sched_idx), .tgt_valid(tgt_valid), .tgt_code(tgt_code)
    );

    cfgmgr_hold #(.PARAM_MODE(PARAM_MODE), .CODE_W(CODE_W)) u_hold (
        .clk(clk), .rst(rst), .issue(issue), .ack_ok(ack_ok),
        .tgt_code(tgt_code), .cur_code(cur_code), .cur_valid(cur_valid),
        .ld_code(ld_code), .cfg_land(cfg_land)
    );

    cfgmgr_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_code(tgt_code),
        .cur_valid(cur_valid), .cur_code(cur_code), .cfg_land(cfg_land),
        .start_req(start_req), .op_done(op_done), .ld_ack(ld_ack),
        .state(state), .issue(issue), .ack_ok(ack_ok), .advance(advance)
    );

    assign mgr_state  = state;
    assign op_enable  = (state == ST_BUSY);
    assign ld_req     = (state == ST_CONFIG);
    assign configured = cur_valid && (state == ST_READY || state == ST_BUSY);
    assign cfg_code   = cur_code;

endmodule

// File: rtl/cfgmgr_checker.sv
module cfgmgr_checker #(
    parameter int unsigned N_ENTRIES  = 4,
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned IDX_W      = 2,
    parameter bit          PARAM_MODE = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              start_req,
    input logic              op_done,
    input logic              ld_ack,
    input logic              op_enable,
    input logic              configured,
    input logic [1:0]        mgr_state,
    input logic [IDX_W-1:0]  sched_idx,
    input logic [CODE_W-1:0] cfg_code,
    input logic              ld_req,
    input logic [CODE_W-1:0] ld_code
);
    logic [IDX_W-1:0] idx_exp;
    always_comb begin
        idx_exp = (sched_idx == IDX_W'(N_ENTRIES - 1)) ? '0 : sched_idx + 1'b1;
    end

    p_en_safe_r3: assert property (@(posedge clk) disable iff (rst)
        op_enable |-> (configured && !ld_req));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !ld_ack) |=> (ld_req && $stable(ld_code)));

    p_ack_land_r8: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_ack) |=> (configured && !ld_req && cfg_code == $past(ld_code)));

    p_done_adv_r5: assert property (@(posedge clk) disable iff (rst)
        (op_enable && op_done) |=> (!op_enable && sched_idx == $past(idx_exp)));

    p_start_run_r4: assert property (@(posedge clk) disable iff (rst)
        (mgr_state == 2'd2 && start_req) |=> op_enable);

    p_stray_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (mgr_state == 2'd2 && ld_ack && !start_req) |=> (mgr_state == 2'd2 && $stable(cfg_code)));

    p_no_req_r10: assert property (@(posedge clk) disable iff (rst)
        !(PARAM_MODE && ld_req));

endmodule

bind cfgmgr_top cfgmgr_checker #(
    .N_ENTRIES(N_ENTRIES), .CODE_W(CODE_W), .IDX_W(IDX_W), .PARAM_MODE(PARAM_MODE)
) u_chk (
    .clk(clk), .rst(rst), .start_req(start_req), .op_done(op_done), .ld_ack(ld_ack),
    .op_enable(op_enable), .configured(configured), .mgr_state(mgr_state),
    .sched_idx(sched_idx), .cfg_code(cfg_code), .ld_req(ld_req), .ld_code(ld_code)
);

// File: tb/cfgmgr_top_test.sv
module cfgmgr_top_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       start = 1'b0, done = 1'b0, stray = 1'b0, ack_m = 1'b0;
    logic [1:0] cvld = 2'b00, cval = 2'b00;
    logic       en, cfgd, lreq;
    logic [1:0] st, idx;
    logic [2:0] code, lcode;

    cfgmgr_top uut (
        .clk(clk), .rst(rst), .start_req(start), .op_done(done),
        .cond_valid(cvld), .cond_val(cval), .ld_ack(ack_m | stray),
        .op_enable(en), .configured(cfgd), .mgr_state(st), .sched_idx(idx),
        .cfg_code(code), .ld_req(lreq), .ld_code(lcode)
    );

    logic       p_start = 1'b0, p_done = 1'b0;
    logic [1:0] p_cvld = 2'b00, p_cval = 2'b00;
    logic       p_en, p_cfgd, p_lreq;
    logic [1:0] p_st, p_idx;
    logic [2:0] p_code, p_lcode;

    cfgmgr_top #(.PARAM_MODE(1'b1)) uut_par (
        .clk(clk), .rst(rst), .start_req(p_start), .op_done(p_done),
        .cond_valid(p_cvld), .cond_val(p_cval), .ld_ack(1'b0),
        .op_enable(p_en), .configured(p_cfgd), .mgr_state(p_st), .sched_idx(p_idx),
        .cfg_code(p_code), .ld_req(p_lreq), .ld_code(p_lcode)
    );

    int n_chk = 0, n_fail = 0, n_req = 0, n_viol = 0, p_nreq = 0, lcnt = 0;
    logic req_q = 1'b0;

    // Loader model with random acknowledge latency of 1 to 5 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (ack_m) begin
                ack_m = 1'b0;
            end else if (lreq) begin
                if (lcnt == 0) begin
                    lcnt = 1 + $urandom_range(0, 4);
                end else begin
                    lcnt--;
                    if (lcnt == 0) ack_m = 1'b1;
                end
            end
        end
    end

    // Monitors, sampled just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (lreq && !req_q) n_req++;
            req_q = lreq;
            if (en && (lreq || !cfgd)) n_viol++;
            if (p_en && (p_lreq || !p_cfgd)) n_viol++;
            if (p_lreq) p_nreq++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wait_st(input int s, input string req);
        for (int k = 0; k < 60 && st != s; k++) @(negedge clk);
        chk(req, st, s);
    endtask

    task automatic pulse_start;
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_done;
        done = 1'b1; @(negedge clk); done = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 state", st, 0);
        chk("R1 enable", en, 0);
        chk("R1 req", lreq, 0);
        chk("R1 index", idx, 0);
        chk("R1 configured", cfgd, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 first state", st, 1);
        chk("R2 first req", lreq, 1);
        chk("R2 first code", lcode, 1);
        chk("R10 param ready", p_st, 2);
        chk("R10 param code", p_code, 1);
        wait_st(2, "R8 ready after ack");
        chk("R8 code", code, 1);
        chk("R8 configured", cfgd, 1);
        chk("R2 one request", n_req, 1);
    endtask

    task automatic t_repeat;
        pulse_start;
        chk("R4 busy", st, 3);
        chk("R4 enable", en, 1);
        pulse_done;
        chk("R5 idle", st, 0);
        chk("R5 index", idx, 1);
        @(negedge clk);
        chk("R6 ready no load", st, 2);
        chk("R6 no req", lreq, 0);
        chk("R6 req count", n_req, 1);
    endtask

    task automatic t_cond_held_start;
        pulse_start;
        pulse_done;
        chk("R5 index", idx, 2);
        repeat (4) @(negedge clk);
        chk("R7 waits", st, 0);
        chk("R7 no req", lreq, 0);
        cvld = 2'b01; cval = 2'b01;
        @(negedge clk);
        cvld = 2'b00; cval = 2'b00;
        chk("R7 req", lreq, 1);
        chk("R7 code b", lcode, 5);
        pulse_start;
        for (int k = 0; k < 60 && st == 1; k++) @(negedge clk);
        chk("R4 held start", st, 3);
        chk("R8 code", code, 5);
    endtask

    task automatic t_next_and_stray;
        pulse_done;
        chk("R5 index", idx, 3);
        @(negedge clk);
        chk("R2 req", lreq, 1);
        chk("R2 code", lcode, 3);
        wait_st(2, "R8 ready");
        chk("R8 code", code, 3);
        stray = 1'b1; @(negedge clk); stray = 1'b0;
        chk("R9 state", st, 2);
        chk("R9 code", code, 3);
    endtask

    task automatic t_wrap;
        pulse_start;
        pulse_done;
        chk("R5 wrap index", idx, 0);
        @(negedge clk);
        chk("R5 wrap code", lcode, 1);
        wait_st(2, "R8 ready");
        pulse_start;
        pulse_start;
        pulse_done;
        @(negedge clk);
        chk("R4 start in busy dropped", st, 2);
        pulse_start;
        pulse_done;
        cvld = 2'b01; cval = 2'b00;
        @(negedge clk);
        cvld = 2'b00;
        chk("R7 code a", lcode, 2);
        wait_st(2, "R8 ready");
        chk("R8 code", code, 2);
        chk("R6 total requests", n_req, 5);
    endtask

    task automatic t_param;
        p_start = 1'b1; @(negedge clk); p_start = 1'b0;
        chk("R10 enable", p_en, 1);
        p_done = 1'b1; @(negedge clk); p_done = 1'b0;
        @(negedge clk);
        chk("R10 ready same code", p_st, 2);
        p_start = 1'b1; @(negedge clk); p_start = 1'b0;
        p_done = 1'b1; @(negedge clk); p_done = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 waits cond", p_st, 0);
        p_cvld = 2'b01; p_cval = 2'b01;
        @(negedge clk);
        p_cvld = 2'b00;
        chk("R10 ready", p_st, 2);
        chk("R10 select", p_code, 5);
        chk("R10 no req", p_nreq, 0);
        chk("R3 enable violations", n_viol, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        report;
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_repeat;
        t_cond_held_start;
        t_next_and_stray;
        t_wrap;
        t_param;
        report;
        $finish;
    end

endmodule